// File: doc/BRIEF.md
# USB Endpoint Handshake Controller

This block is the transaction engine for a single endpoint of a full-speed USB device. A token decoder upstream presents each token as a kind and an endpoint number. The engine decides whether the token belongs to it. For IN tokens it answers with a data packet, NAK or STALL. For OUT and SETUP tokens it counts the data bytes that follow and answers with a handshake once the end of the packet is seen. It also keeps the DATA0/DATA1 toggle for IN traffic and the payload length, and it reports a 3-bit completion code.

Software arms the endpoint by writing the payload length. For IN that length is the number of bytes to send. For OUT it is the largest number of bytes accepted. A write-1 strobe disarms the endpoint before a transaction starts. When a transaction completes, the endpoint disarms itself and raises a one-cycle event. The buffer start address is a fixed base plus an 8-byte-aligned segment offset. The serial line coding, CRC and the packet memory sit outside the block.

Top module: `usb_ep_engine`

## Requirements
- R1: After reset, rsp_vld, evt and overrun are 0, status is 000, len_rd is 0 and buf_addr equals BASE_ADDR.
- R2: buf_addr always equals BASE_ADDR + 8 × seg (seg is the last value written with seg_wr).
- R3: A token is acted on only when tok_ep equals the configured endpoint number and the mode fits. Token kind 00 (OUT) needs mode 01. Kind 01 (IN) needs mode 10. Kind 10 (SETUP) needs mode 01 or 10. Kind 11 is never acted on. Modes 00 and 11 ignore every token and produce no response.
- R4: A matching IN token on a non-stalled endpoint gets a response one cycle later. If the endpoint is armed, rsp = 11 (DATA) and data_pid equals the toggle. If it is unarmed and not isochronous, rsp = 01 (NAK), status = 001 and there is no event.
- R5: A clr_rdy pulse disarms an armed endpoint, so the next IN token is answered with NAK.
- R6: in_fin after an IN data response completes the transfer. Status becomes 000, evt pulses for one cycle, the toggle flips, the endpoint disarms and len_rd keeps the armed length.
- R7: rx_eop after an OUT packet on an armed, non-stalled, non-isochronous endpoint answers rsp = 00 (ACK). Status becomes 010 when rx_pid1 = 0 and 110 when rx_pid1 = 1, len_rd becomes the number of bytes received, evt pulses and the endpoint disarms.
- R8: If an OUT packet carries more bytes than the armed maximum, overrun becomes 1 and len_rd holds the maximum. overrun stays 1 until the next length write clears it.
- R9: A matching SETUP is always answered with ACK at rx_eop, armed or not and stalled or not. Status becomes 011 and evt pulses. overrun is set if more than SETUP_LEN (8) bytes arrived.
- R10: With the stall bit set, an IN token is answered with rsp = 10 (STALL) one cycle later. An OUT packet is answered with STALL at rx_eop, with no event and len_rd unchanged.
- R11: With the clear-stall-on-setup bit set, a SETUP removes the stall, so later OUT packets are acknowledged. With the bit clear, the stall remains.
- R12: An isochronous endpoint never sends a handshake. Completion of an OUT or IN transfer sets status 111 and pulses evt, and the toggle does not flip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration fields below |
| cfg_ep | input | EPN_W | Endpoint number to match |
| cfg_mode | input | 2 | 00 off, 01 OUT, 10 IN, 11 off |
| cfg_iso | input | 1 | Isochronous endpoint (no handshakes) |
| cfg_stall | input | 1 | Answer with STALL |
| cfg_clr_stall_setup | input | 1 | A received SETUP clears the stall |
| cfg_toggle | input | 1 | Toggle value for the next IN (0 = DATA0) |
| seg_wr | input | 1 | Write strobe for the buffer segment |
| seg_val | input | SEG_W | Buffer segment, in units of 8 bytes |
| len_wr | input | 1 | Length write; arms the endpoint |
| len_val | input | LEN_W | Bytes to send (IN) or maximum accepted (OUT) |
| clr_rdy | input | 1 | Write-1 disarm strobe |
| tok_valid | input | 1 | A decoded token is present |
| tok_kind | input | 2 | 00 OUT, 01 IN, 10 SETUP |
| tok_ep | input | EPN_W | Token endpoint number |
| rx_byte | input | 1 | One received data byte |
| rx_eop | input | 1 | End of the received data packet |
| rx_pid1 | input | 1 | Received data packet was DATA1 |
| in_fin | input | 1 | IN packet finished (host ACK, or sent if isochronous) |
| rsp_vld | output | 1 | A response is sent this cycle |
| rsp | output | 2 | 00 ACK, 01 NAK, 10 STALL, 11 DATA |
| data_pid | output | 1 | PID of the IN data packet (1 = DATA1) |
| buf_addr | output | ADDR_W | Buffer start address |
| status | output | 3 | Last completion code |
| overrun | output | 1 | Sticky data-overrun flag |
| evt | output | 1 | One-cycle completion event |
| len_rd | output | LEN_W | Length readback |

## Verification
A wrong armed flag shows at the ports within one cycle of the next matching IN token, as DATA where NAK was due or the reverse. A wrong toggle shows on data_pid at the next armed IN. A wrong byte count or maximum shows on len_rd and overrun in the cycle right after rx_eop. A stale stall bit shows as a STALL one cycle after an IN token, or at the end of the next OUT packet. An exhaustive sweep over token kind, endpoint number and mode exposes any mismatch in the token filter at the first affected token.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

  typedef enum logic [1:0] {
    TK_OUT   = 2'b00,
    TK_IN    = 2'b01,
    TK_SETUP = 2'b10,
    TK_NONE  = 2'b11
  } tok_kind_t;

  typedef enum logic [1:0] {
    RSP_ACK   = 2'b00,
    RSP_NAK   = 2'b01,
    RSP_STALL = 2'b10,
    RSP_DATA  = 2'b11
  } rsp_t;

  typedef enum logic [1:0] {
    MD_OFF   = 2'b00,
    MD_OUT   = 2'b01,
    MD_IN    = 2'b10,
    MD_UNDEF = 2'b11
  } mode_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_RX   = 2'b01,
    PH_INW  = 2'b10
  } phase_t;

  localparam logic [2:0] CODE_IN_ACK = 3'b000;
  localparam logic [2:0] CODE_IN_NAK = 3'b001;
  localparam logic [2:0] CODE_SETUP  = 3'b011;
  localparam logic [2:0] CODE_ISO    = 3'b111;

  // OUT completion code: the received data PID sits in the top bit
  function automatic logic [2:0] out_code(input logic pid1);
    return {pid1, 2'b10};
  endfunction

endpackage

// File: rtl/usb_ep_match.sv
module usb_ep_match
  import usb_ep_pkg::*;
#(
  parameter int EPN_W = 4
) (
  input  logic             tok_valid,
  input  logic [1:0]       tok_kind,
  input  logic [EPN_W-1:0] tok_ep,
  input  logic [EPN_W-1:0] cfg_ep,
  input  logic [1:0]       mode,
  output logic             hit_out,
  output logic             hit_in,
  output logic             hit_setup
);
  logic addr_ok;
  logic is_out_ep;
  logic is_in_ep;

  assign addr_ok   = tok_valid && (tok_ep == cfg_ep);
  assign is_out_ep = (mode == MD_OUT);
  assign is_in_ep  = (mode == MD_IN);

  assign hit_out   = addr_ok && (tok_kind == TK_OUT) && is_out_ep;
  assign hit_in    = addr_ok && (tok_kind == TK_IN) && is_in_ep;
  assign hit_setup = addr_ok && (tok_kind == TK_SETUP) && (is_out_ep || is_in_ep);
endmodule

// File: rtl/usb_ep_rxcount.sv
module usb_ep_rxcount #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/usb_ep_addr.sv
module usb_ep_addr #(
  parameter int          SEG_W     = 6,
  parameter int          ADDR_W    = 16,
  parameter int unsigned BASE_ADDR = 32'h0100
) (
  input  logic [SEG_W-1:0]  seg,
  output logic [ADDR_W-1:0] addr
);
  function automatic logic [ADDR_W-1:0] seg_start(input logic [SEG_W-1:0] s);
    return ADDR_W'(BASE_ADDR) + (ADDR_W'(s) << 3);
  endfunction

  assign addr = seg_start(seg);
endmodule

// File: rtl/usb_ep_engine.sv
module usb_ep_engine
  import usb_ep_pkg::*;
#(
  parameter int          LEN_W     = 9,
  parameter int          EPN_W     = 4,
  parameter int          SEG_W     = 6,
  parameter int          ADDR_W    = 16,
  parameter int unsigned BASE_ADDR = 32'h0100,
  parameter int          SETUP_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [EPN_W-1:0]  cfg_ep,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_iso,
  input  logic              cfg_stall,
  input  logic              cfg_clr_stall_setup,
  input  logic              cfg_toggle,
  input  logic              seg_wr,
  input  logic [SEG_W-1:0]  seg_val,
  input  logic              len_wr,
  input  logic [LEN_W-1:0]  len_val,
  input  logic              clr_rdy,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic [EPN_W-1:0]  tok_ep,
  input  logic              rx_byte,
  input  logic              rx_eop,
  input  logic              rx_pid1,
  input  logic              in_fin,
  output logic              rsp_vld,
  output logic [1:0]        rsp,
  output logic              data_pid,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [2:0]        status,
  output logic              overrun,
  output logic              evt,
  output logic [LEN_W-1:0]  len_rd
);
  localparam int CNT_W = LEN_W + 1;

  logic [EPN_W-1:0] ep_q;
  mode_t            mode_q;
  logic             iso_q, stall_q, cstall_q, tog_q;
  logic [SEG_W-1:0] seg_q;
  logic [LEN_W-1:0] len_q;
  logic             armed_q, setup_q;
  phase_t           ph_q;
  rsp_t             rsp_q;
  logic             rsp_vld_q, pid_q, ovr_q, evt_q;
  logic [2:0]       status_q;

  // named internal events
  logic             hit_out, hit_in, hit_setup;
  logic             in_rx, tok_take, eop_go, in_done;
  logic [CNT_W-1:0] rx_cnt;
  logic             cnt_over, setup_over;

  assign in_rx    = (ph_q == PH_RX);
  assign tok_take = tok_valid && !in_rx;
  assign eop_go   = in_rx && rx_eop;
  assign in_done  = (ph_q == PH_INW) && in_fin && !tok_valid;

  usb_ep_match #(.EPN_W(EPN_W)) match_i (
    .tok_valid (tok_take),
    .tok_kind  (tok_kind),
    .tok_ep    (tok_ep),
    .cfg_ep    (ep_q),
    .mode      (mode_q),
    .hit_out   (hit_out),
    .hit_in    (hit_in),
    .hit_setup (hit_setup)
  );

  usb_ep_rxcount #(.W(CNT_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hit_out || hit_setup),
    .inc   (in_rx && rx_byte && !rx_eop),
    .cnt   (rx_cnt)
  );

  usb_ep_addr #(.SEG_W(SEG_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) addr_i (
    .seg  (seg_q),
    .addr (buf_addr)
  );

  assign cnt_over   = rx_cnt > {1'b0, len_q};
  assign setup_over = rx_cnt > CNT_W'(SETUP_LEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ep_q      <= '0;
      mode_q    <= MD_OFF;
      iso_q     <= 1'b0;
      stall_q   <= 1'b0;
      cstall_q  <= 1'b0;
      tog_q     <= 1'b0;
      seg_q     <= '0;
      len_q     <= '0;
      armed_q   <= 1'b0;
      setup_q   <= 1'b0;
      ph_q      <= PH_IDLE;
      rsp_q     <= RSP_ACK;
      rsp_vld_q <= 1'b0;
      pid_q     <= 1'b0;
      ovr_q     <= 1'b0;
      evt_q     <= 1'b0;
      status_q  <= CODE_IN_ACK;
    end else begin
      rsp_vld_q <= 1'b0;
      evt_q     <= 1'b0;

      if (tok_take) begin
        ph_q <= PH_IDLE;
        if (hit_in) begin
          if (stall_q) begin
            rsp_vld_q <= 1'b1;
            rsp_q     <= RSP_STALL;
          end else if (armed_q) begin
            rsp_vld_q <= 1'b1;
            rsp_q     <= RSP_DATA;
            pid_q     <= tog_q;
            ph_q      <= PH_INW;
          end else if (!iso_q) begin
            rsp_vld_q <= 1'b1;
            rsp_q     <= RSP_NAK;
            status_q  <= CODE_IN_NAK;
          end
        end else if (hit_out || hit_setup) begin
          ph_q    <= PH_RX;
          setup_q <= hit_setup;
        end
      end else if (eop_go) begin
        ph_q <= PH_IDLE;
        if (setup_q) begin
          rsp_vld_q <= 1'b1;
          rsp_q     <= RSP_ACK;
          status_q  <= CODE_SETUP;
          evt_q     <= 1'b1;
          ovr_q     <= ovr_q | setup_over;
          if (cstall_q) stall_q <= 1'b0;
        end else if (stall_q) begin
          rsp_vld_q <= 1'b1;
          rsp_q     <= RSP_STALL;
        end else if (!armed_q) begin
          if (!iso_q) begin
            rsp_vld_q <= 1'b1;
            rsp_q     <= RSP_NAK;
          end
        end else begin
          len_q    <= cnt_over ? len_q : rx_cnt[LEN_W-1:0];
          ovr_q    <= ovr_q | cnt_over;
          armed_q  <= 1'b0;
          evt_q    <= 1'b1;
          status_q <= iso_q ? CODE_ISO : out_code(rx_pid1);
          if (!iso_q) begin
            rsp_vld_q <= 1'b1;
            rsp_q     <= RSP_ACK;
          end
        end
      end else if (in_done) begin
        ph_q     <= PH_IDLE;
        armed_q  <= 1'b0;
        evt_q    <= 1'b1;
        status_q <= iso_q ? CODE_ISO : CODE_IN_ACK;
        if (!iso_q) tog_q <= ~tog_q;
      end

      // software writes take precedence over same-cycle hardware updates
      if (cfg_wr) begin
        ep_q     <= cfg_ep;
        mode_q   <= mode_t'(cfg_mode);
        iso_q    <= cfg_iso;
        stall_q  <= cfg_stall;
        cstall_q <= cfg_clr_stall_setup;
        tog_q    <= cfg_toggle;
      end
      if (seg_wr) seg_q <= seg_val;
      if (len_wr) begin
        len_q   <= len_val;
        armed_q <= 1'b1;
        ovr_q   <= 1'b0;
      end
      if (clr_rdy) armed_q <= 1'b0;
    end
  end

  assign rsp_vld  = rsp_vld_q;
  assign rsp      = rsp_q;
  assign data_pid = pid_q;
  assign status   = status_q;
  assign overrun  = ovr_q;
  assign evt      = evt_q;
  assign len_rd   = len_q;
endmodule

// File: rtl/usb_ep_engine_chk.sv
module usb_ep_engine_chk
  import usb_ep_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       evt,
  input logic       rsp_vld,
  input logic [1:0] rsp,
  input logic [2:0] status,
  input logic       stall,
  input logic       ovr,
  input logic       in_rx,
  input logic       armed,
  input logic       len_wr
);
  // R6: completion event lasts exactly one cycle
  a_r6_evt_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

  // R4: a NAK never coincides with a completion event
  a_r4_nak_without_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp == RSP_NAK) |-> !evt);

  // R4: an event never reports the IN NAK code
  a_r4_evt_not_nak_code: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> status != CODE_IN_NAK);

  // R10: no data packet leaves a stalled endpoint
  a_r10_stall_blocks_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp == RSP_DATA) |-> !$past(stall));

  // R8: overrun only rises at the end of a received packet
  a_r8_ovr_from_rx: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(in_rx));

  // R6: a data completion leaves the endpoint disarmed
  a_r6_done_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && status != CODE_SETUP && !$past(len_wr)) |-> !armed);
endmodule

bind usb_ep_engine usb_ep_engine_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt     (evt),
  .rsp_vld (rsp_vld),
  .rsp     (rsp),
  .status  (status),
  .stall   (stall_q),
  .ovr     (overrun),
  .in_rx   (in_rx),
  .armed   (armed_q),
  .len_wr  (len_wr)
);

// File: tb/usb_ep_engine_tb_top.sv
`timescale 1ns/1ps
module usb_ep_engine_tb_top;
  localparam int BASE = 'h0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_iso = 0, cfg_stall = 0, cfg_cst = 0, cfg_tog = 0;
  logic [3:0] cfg_ep = 0;
  logic [1:0] cfg_mode = 0;
  logic seg_wr = 0;
  logic [5:0] seg_val = 0;
  logic len_wr = 0;
  logic [8:0] len_val = 0;
  logic clr_rdy = 0, tok_valid = 0, rx_byte = 0, rx_eop = 0, rx_pid1 = 0, in_fin = 0;
  logic [1:0] tok_kind = 0;
  logic [3:0] tok_ep = 0;
  logic rsp_vld, data_pid, overrun, evt;
  logic [1:0] rsp;
  logic [15:0] buf_addr;
  logic [2:0] status;
  logic [8:0] len_rd;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_ep_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ep(cfg_ep), .cfg_mode(cfg_mode),
    .cfg_iso(cfg_iso), .cfg_stall(cfg_stall), .cfg_clr_stall_setup(cfg_cst),
    .cfg_toggle(cfg_tog), .seg_wr(seg_wr), .seg_val(seg_val), .len_wr(len_wr),
    .len_val(len_val), .clr_rdy(clr_rdy), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .tok_ep(tok_ep), .rx_byte(rx_byte), .rx_eop(rx_eop), .rx_pid1(rx_pid1),
    .in_fin(in_fin), .rsp_vld(rsp_vld), .rsp(rsp), .data_pid(data_pid),
    .buf_addr(buf_addr), .status(status), .overrun(overrun), .evt(evt), .len_rd(len_rd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clk1();
    @(negedge clk);
  endtask

  task automatic cfg(input int ep, input int mode, input bit iso, input bit stl,
                     input bit cst, input bit tog);
    cfg_ep = 4'(ep); cfg_mode = 2'(mode); cfg_iso = iso; cfg_stall = stl;
    cfg_cst = cst; cfg_tog = tog; cfg_wr = 1;
    clk1(); cfg_wr = 0;
  endtask

  task automatic arm(input int n);
    len_val = 9'(n); len_wr = 1; clk1(); len_wr = 0;
  endtask

  task automatic token(input int kind, input int ep);
    tok_kind = 2'(kind); tok_ep = 4'(ep); tok_valid = 1; clk1(); tok_valid = 0;
  endtask

  task automatic bytes(input int n);
    for (int i = 0; i < n; i++) begin rx_byte = 1; clk1(); rx_byte = 0; end
  endtask

  task automatic eop(input bit pid);
    rx_pid1 = pid; rx_eop = 1; clk1(); rx_eop = 0;
  endtask

  task automatic fin();
    in_fin = 1; clk1(); in_fin = 0;
  endtask

  // response encoding: 0 = none, 4 + rsp code otherwise
  function automatic int rcode();
    return rsp_vld ? 4 + int'(rsp) : 0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) clk1();
    rst_n = 1;
    clk1();
    // R1 reset state
    chk("R1 rsp_vld", rsp_vld, 0);
    chk("R1 evt", evt, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 status", status, 0);
    chk("R1 len_rd", len_rd, 0);
    chk("R1 buf_addr", buf_addr, BASE);

    // R2 address over every segment value
    for (int s = 0; s < 64; s++) begin
      seg_val = 6'(s); seg_wr = 1; clk1(); seg_wr = 0;
      chk("R2 buf_addr", buf_addr, BASE + s * 8);
    end

    // R3 exhaustive token filter: endpoint 5
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 4; k++)
        for (int e = 0; e < 16; e++) begin
          int c1, c2, exp1, exp2;
          bit hit;
          cfg(5, m, 0, 0, 0, 0);
          arm(3);
          token(k, e);
          c1 = rcode();
          eop(0);
          c2 = rcode();
          hit = (e == 5) && ((k == 0 && m == 1) || (k == 1 && m == 2) ||
                             (k == 2 && (m == 1 || m == 2)));
          exp1 = (hit && k == 1) ? 4 + 3 : 0;
          exp2 = (hit && k != 1) ? 4 + 0 : 0;
          chk("R3 token filter", c1 * 8 + c2, exp1 * 8 + exp2);
        end

    // R4 / R6 IN flow with toggle tracking
    cfg(2, 2, 0, 0, 0, 0);
    begin
      bit tog = 0;
      for (int t = 0; t < 4; t++) begin
        arm(20 + t);
        token(1, 2);
        chk("R4 IN data rsp", rcode(), 4 + 3);
        chk("R4 IN data pid", data_pid, tog);
        fin();
        chk("R6 evt", evt, 1);
        chk("R6 status", status, 0);
        chk("R6 len_rd kept", len_rd, 20 + t);
        clk1();
        chk("R6 evt one cycle", evt, 0);
        tog = ~tog;
      end
    end
    token(1, 2);
    chk("R6 disarmed NAK", rcode(), 4 + 1);
    chk("R4 NAK status", status, 1);
    chk("R4 NAK no evt", evt, 0);

    // R5 clear-ready strobe
    arm(4);
    clr_rdy = 1; clk1(); clr_rdy = 0;
    token(1, 2);
    chk("R5 NAK after clr_rdy", rcode(), 4 + 1);

    // R7 / R8 OUT sweep over maximum and byte count
    cfg(1, 1, 0, 0, 0, 0);
    for (int mx = 0; mx < 7; mx++)
      for (int n = 0; n < 9; n++) begin
        arm(mx);
        chk("R8 overrun cleared by arm", overrun, 0);
        token(0, 1);
        bytes(n);
        eop(n[0]);
        chk("R7 OUT ack", rcode(), 4 + 0);
        chk("R7 OUT status", status, n[0] ? 6 : 2);
        chk("R7 OUT evt", evt, 1);
        chk("R8 len_rd", len_rd, (n > mx) ? mx : n);
        chk("R8 overrun", overrun, (n > mx) ? 1 : 0);
      end
    token(0, 1); bytes(1); eop(0);
    chk("R7 disarmed NAK", rcode(), 4 + 1);

    // R9 setup, length limit and overrun
    arm(2);
    token(2, 1); bytes(8); eop(0);
    chk("R9 setup ack", rcode(), 4 + 0);
    chk("R9 setup status", status, 3);
    chk("R9 setup evt", evt, 1);
    chk("R9 8 bytes no overrun", overrun, 0);
    token(2, 1); bytes(9); eop(0);
    chk("R9 9 bytes overrun", overrun, 1);

    // R10 stall on IN and OUT
    cfg(3, 2, 0, 1, 0, 0);
    arm(5);
    token(1, 3);
    chk("R10 IN stall", rcode(), 4 + 2);
    cfg(3, 1, 0, 1, 0, 0);
    arm(6);
    token(0, 3); bytes(2); eop(0);
    chk("R10 OUT stall", rcode(), 4 + 2);
    chk("R10 OUT no evt", evt, 0);
    chk("R10 len unchanged", len_rd, 6);

    // R11 clear stall on setup, and its absence
    cfg(3, 1, 0, 1, 0, 0);
    token(2, 3); bytes(8); eop(0);
    arm(4); token(0, 3); bytes(2); eop(0);
    chk("R11 stall kept", rcode(), 4 + 2);
    cfg(3, 1, 0, 1, 1, 0);
    token(2, 3); bytes(8); eop(0);
    chk("R11 setup ack while stalled", rcode(), 4 + 0);
    arm(4); token(0, 3); bytes(2); eop(1);
    chk("R11 stall removed", rcode(), 4 + 0);
    chk("R11 status", status, 6);

    // R12 isochronous OUT and IN
    cfg(4, 1, 1, 0, 0, 0);
    arm(10);
    token(0, 4); bytes(3); eop(0);
    chk("R12 iso OUT no handshake", rcode(), 0);
    chk("R12 iso OUT evt", evt, 1);
    chk("R12 iso OUT status", status, 7);
    chk("R12 iso OUT len", len_rd, 3);
    cfg(4, 2, 1, 0, 0, 0);
    for (int t = 0; t < 2; t++) begin
      arm(8);
      token(1, 4);
      chk("R12 iso IN data", rcode(), 4 + 3);
      chk("R12 iso IN pid fixed", data_pid, 0);
      fin();
      chk("R12 iso IN status", status, 7);
      chk("R12 iso IN evt", evt, 1);
    end
    token(1, 4);
    chk("R12 iso IN unarmed silent", rcode(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule